// File: doc/BRIEF.md
# Late-Parity Checker with Stretched Error Flag

This block checks the parity of a registered command/address word against a parity bit that arrives one or two clocks after the word it covers. On every clock edge where the chip-select gating allows it, the block reduces the configured subset of data lanes to one parity bit and stores it in a short delay pipeline. It then combines the stored bit with the late parity input. The result drives a partial-parity output and an active-low error flag. Once the error flag is raised, it stays low for two active clocks.

The configuration pins select the lane subset and the latency. With the cascade pin low, parity arrives one clock after the data. With it high, the block behaves as the reporting end of a cascaded pair: the stored parity passes through one more stage, and parity arrives two clocks after the data. When both select inputs are high, the whole block is frozen. Reset is synchronous and active high.

Top module: `pc_delayed_parity`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `ppo` is 0 and `err_n` is 1, and both stored parity stages are cleared to 0.
- R2: With `cfg_casc`=0, the value of `ppo` after an active edge equals the parity of the enabled lanes captured at the previous active edge XOR the `par_in` sampled at this edge.
- R3: With `cfg_casc`=1, `ppo` after an active edge equals the enabled-lane parity captured two active edges earlier XOR the current `par_in`.
- R4: With `cfg_split`=0 and `cfg_casc`=0, the enabled lanes are inputs 2, 3, 5, 6 and 8 to 25. Input n is `data_in[n-1]`.
- R5: With `cfg_split`=1 and `cfg_casc`=0, only inputs 2, 3, 5, 6 and 8 to 14 count. Toggling any other lane leaves `ppo` unchanged.
- R6: With `cfg_split`=1 and `cfg_casc`=1, the enabled lanes are inputs 1 to 6, 8 to 10, 12 and 13.
- R7: An active edge that computes `ppo`=1 drives `err_n` low at the same edge, so `ppo` high always comes with `err_n` low.
- R8: After it falls, `err_n` stays low for exactly two active edges' worth of cycles: it returns high at the second following active edge that finds no mismatch.
- R9: A mismatch found while the error is held restarts the two-cycle hold from that edge.
- R10: An edge where `dcs_n` and `csr_n` are both high is inactive. `ppo`, `err_n`, the hold count and the parity pipeline all keep their values.
- R11: With `cfg_split`=0 and `cfg_casc`=1, the lane set of R4 applies with the two-cycle latency of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; has priority over gating |
| data_in | input | 25 | Command/address word; bit n-1 is input n |
| cfg_casc | input | 1 | 0: one-cycle parity latency; 1: cascaded pair, two-cycle latency |
| cfg_split | input | 1 | 0: full-width lane set; 1: half-width lane sets |
| par_in | input | 1 | Late parity bit for the word captured one or two active edges earlier |
| dcs_n | input | 1 | Chip select, active low |
| csr_n | input | 1 | Second chip select, active low; both high freezes the block |
| ppo | output | 1 | Partial parity result, 1 on odd total |
| err_n | output | 1 | Parity error, active low, stretched |

## Verification
On every cycle, the assertions check the reset values, the pairing of `ppo` high with `err_n` low, the minimum length of the low pulse, a release only after a clean edge, and the freezing of both outputs on gated edges. Only the bench's scenarios can show the behaviours that depend on data history: the one- and two-edge latency, the exact lane set of each configuration, the restart of the hold by a fresh mismatch, and the pipeline itself staying frozen while gated. The bench tests these against a model that replays the parity history of active edges.

// File: rtl/pc_pkg.sv
package pc_pkg;

    // Configuration encoding: {cfg_split, cfg_casc}
    typedef enum logic [1:0] {
        MODE_WIDE      = 2'b00,
        MODE_WIDE_CASC = 2'b01,
        MODE_SPLIT_A   = 2'b10,
        MODE_SPLIT_B   = 2'b11
    } pc_mode_e;

    localparam int unsigned PC_DATA_W   = 25;
    localparam int unsigned PC_MAX_LAT  = 2;
    localparam int unsigned PC_HOLD_CYC = 2;

    // Result of one check, as stored in the output register
    typedef struct packed {
        logic odd;     // partial parity, 1 on odd total
        logic err_n;   // stretched error flag, active low
    } pc_flag_t;

    // Lane idx (0-based) carries input number idx+1
    function automatic logic lane_used(pc_mode_e m, int unsigned idx);
        logic hole;
        hole = (idx == 0) || (idx == 3) || (idx == 6);
        case (m)
            MODE_WIDE, MODE_WIDE_CASC: return !hole && (idx <= 24);
            MODE_SPLIT_A:              return !hole && (idx <= 13);
            MODE_SPLIT_B:              return (idx <= 5) || (idx >= 7 && idx <= 9) ||
                                              (idx == 11) || (idx == 12);
            default:                   return 1'b0;
        endcase
    endfunction

    // Parity latency in active edges: the cascade bit adds one stage
    function automatic int unsigned mode_latency(pc_mode_e m);
        return m[0] ? 2 : 1;
    endfunction

endpackage

// File: rtl/pc_lane_mask.sv
module pc_lane_mask
    import pc_pkg::*;
#(
    parameter int unsigned DATA_W = PC_DATA_W
) (
    input  pc_mode_e          mode,
    input  logic [DATA_W-1:0] data,
    output logic              par
);
    logic [DATA_W-1:0] lane_en;

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign lane_en[i] = lane_used(mode, i);
    end

    assign par = ^(data & lane_en);
endmodule

// File: rtl/pc_parity_pipe.sv
module pc_parity_pipe #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic d_par,
    input  logic late,
    output logic tap
);
    localparam int unsigned LAST = DEPTH - 1;

    logic [DEPTH-1:0] stg;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stg
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)      stg[0] <= 1'b0;
                else if (adv) stg[0] <= d_par;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)      stg[s] <= 1'b0;
                else if (adv) stg[s] <= stg[s-1];
            end
        end
    end

    assign tap = late ? stg[LAST] : stg[0];
endmodule

// File: rtl/pc_err_hold.sv
module pc_err_hold
    import pc_pkg::*;
#(
    parameter int unsigned HOLD_CYC = PC_HOLD_CYC
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    input  logic     mismatch,
    output pc_flag_t flag
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag.odd   <= 1'b0;
            flag.err_n <= 1'b1;
            cnt        <= '0;
        end else if (adv) begin
            flag.odd <= mismatch;
            if (mismatch) begin
                flag.err_n <= 1'b0;
                cnt        <= RELOAD;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                flag.err_n <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pc_delayed_parity.sv
module pc_delayed_parity
    import pc_pkg::*;
#(
    parameter int unsigned DATA_W   = PC_DATA_W,
    parameter int unsigned HOLD_CYC = PC_HOLD_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic              cfg_casc,
    input  logic              cfg_split,
    input  logic              par_in,
    input  logic              dcs_n,
    input  logic              csr_n,
    output logic              ppo,
    output logic              err_n
);
    pc_mode_e mode;
    logic     adv;
    logic     word_par;
    logic     tap;
    logic     late;
    pc_flag_t flag;

    assign mode = pc_mode_e'({cfg_split, cfg_casc});
    assign adv  = !(dcs_n && csr_n);
    assign late = (mode_latency(mode) == PC_MAX_LAT);

    pc_lane_mask #(.DATA_W(DATA_W)) u_mask (
        .mode (mode),
        .data (data_in),
        .par  (word_par)
    );

    pc_parity_pipe #(.DEPTH(PC_MAX_LAT)) u_pipe (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .d_par (word_par),
        .late  (late),
        .tap   (tap)
    );

    pc_err_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .mismatch (tap ^ par_in),
        .flag     (flag)
    );

    assign ppo   = flag.odd;
    assign err_n = flag.err_n;
endmodule

// File: rtl/pc_delayed_parity_chk.sv
module pc_delayed_parity_chk (
    input logic clk,
    input logic rst,
    input logic dcs_n,
    input logic csr_n,
    input logic ppo,
    input logic err_n
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!ppo && err_n));

    p_odd_flags_err_r7: assert property (@(posedge clk) disable iff (rst)
        ppo |-> !err_n);

    p_fall_with_odd_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n) |-> ppo);

    p_hold_low_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n) |=> !err_n);

    p_release_clean_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(err_n) && !$past(rst)) |-> !$past(ppo));

    p_gate_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        (dcs_n && csr_n) |=> ($stable(ppo) && $stable(err_n)));
endmodule

bind pc_delayed_parity pc_delayed_parity_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .dcs_n (dcs_n),
    .csr_n (csr_n),
    .ppo   (ppo),
    .err_n (err_n)
);

// File: tb/sim_pc_delayed_parity.sv
module sim_pc_delayed_parity;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [24:0] data_in = '0;
    logic        cfg_casc = 1'b0;
    logic        cfg_split = 1'b0;
    logic        par_in = 1'b0;
    logic        dcs_n = 1'b0;
    logic        csr_n = 1'b1;
    logic        ppo;
    logic        err_n;

    int vectors = 0;
    int miscompares = 0;
    int sel_rot = 0;

    // reference state: parity of recent active edges, newest first
    bit h_new = 0, h_old = 0;
    bit m_ppo = 0, m_err_n = 1;
    int m_hold = 0;

    always #4 clk = ~clk;

    pc_delayed_parity u0 (
        .clk(clk), .rst(rst), .data_in(data_in), .cfg_casc(cfg_casc),
        .cfg_split(cfg_split), .par_in(par_in), .dcs_n(dcs_n),
        .csr_n(csr_n), .ppo(ppo), .err_n(err_n)
    );

    function automatic bit ref_par(logic [24:0] d, bit sp, bit cs);
        bit acc = 0;
        for (int n = 1; n <= 25; n++) begin
            bit use_it;
            if (sp && cs)      use_it = n inside {[1:6], [8:10], 12, 13};
            else if (sp)       use_it = n inside {2, 3, 5, 6, [8:14]};
            else               use_it = n inside {2, 3, 5, 6, [8:25]};
            if (use_it) acc ^= d[n-1];
        end
        return acc;
    endfunction

    task automatic step(string req, logic [24:0] d, bit inject, bit gate, bit r);
        bit tap, odd;
        @(negedge clk);
        rst     = r;
        data_in = d;
        if (gate) begin
            dcs_n = 1'b1; csr_n = 1'b1;
        end else begin
            sel_rot++;
            case (sel_rot % 3)
                0: begin dcs_n = 1'b0; csr_n = 1'b1; end
                1: begin dcs_n = 1'b1; csr_n = 1'b0; end
                default: begin dcs_n = 1'b0; csr_n = 1'b0; end
            endcase
        end
        tap = cfg_casc ? h_old : h_new;
        par_in = tap ^ inject;
        if (r) begin
            h_new = 0; h_old = 0; m_ppo = 0; m_err_n = 1; m_hold = 0;
        end else if (!gate) begin
            odd = tap ^ par_in;
            h_old = h_new;
            h_new = ref_par(d, cfg_split, cfg_casc);
            m_ppo = odd;
            if (odd) begin
                m_err_n = 0; m_hold = 1;
            end else if (m_hold > 0) begin
                m_hold--;
            end else begin
                m_err_n = 1;
            end
        end
        @(posedge clk);
        #1;
        vectors++;
        if (ppo !== m_ppo || err_n !== m_err_n) begin
            miscompares++;
            $display("FAIL %s: ppo/err_n = %b/%b, expected %b/%b", req, ppo, err_n, m_ppo, m_err_n);
        end
    endtask

    task automatic run_mode(string req, bit sp, bit cs, int n);
        cfg_split = sp; cfg_casc = cs;
        step(req, '0, 0, 0, 1);
        for (int i = 0; i < n; i++)
            step(req, 25'($urandom), (i % 7) == 3, (i % 11) == 5, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1 reset state
        step("R1", 25'h1ffffff, 1, 0, 1);
        step("R1", 25'h0aaaaaa, 1, 0, 1);

        // lane sets and latencies
        run_mode("R2 R4", 0, 0, 60);
        run_mode("R2 R5", 1, 0, 60);
        run_mode("R3 R6", 1, 1, 60);
        run_mode("R3 R11", 0, 1, 60);

        // R5: disabled lanes (inputs 1, 4, 7, 15..25) have no effect
        cfg_split = 1; cfg_casc = 0;
        step("R5", '0, 0, 0, 1);
        for (int i = 0; i < 12; i++)
            step("R5", 25'h1ffc049 & 25'($urandom), 0, 0, 0);

        // R6: inputs 7, 11, 14..25 ignored in split B
        cfg_split = 1; cfg_casc = 1;
        step("R6", '0, 0, 0, 1);
        for (int i = 0; i < 12; i++)
            step("R6", 25'h1ffe440 & 25'($urandom), 0, 0, 0);

        // R7 R8: single error, held two cycles then released
        cfg_split = 0; cfg_casc = 0;
        step("R8", '0, 0, 0, 1);
        step("R7", 25'h0000123, 1, 0, 0);
        for (int i = 0; i < 4; i++) step("R8", 25'($urandom), 0, 0, 0);

        // R9: fresh mismatch during hold restarts it
        step("R9", 25'h0000010, 1, 0, 0);
        step("R9", 25'h0000020, 0, 0, 0);
        step("R9", 25'h0000040, 1, 0, 0);
        for (int i = 0; i < 4; i++) step("R9", 25'($urandom), 0, 0, 0);
        step("R9", 25'h1, 1, 0, 0);
        step("R9", 25'h2, 1, 0, 0);
        for (int i = 0; i < 4; i++) step("R9", 25'($urandom), 0, 0, 0);

        // R10: gating freezes outputs, hold count and pipeline
        step("R10", 25'h00f00f0, 1, 0, 0);
        for (int i = 0; i < 5; i++) step("R10", 25'($urandom), i[0], 1, 0);
        for (int i = 0; i < 4; i++) step("R10", 25'($urandom), 0, 0, 0);
        cfg_casc = 1;
        step("R10", '0, 0, 0, 1);
        step("R10", 25'h0000006, 0, 0, 0);
        for (int i = 0; i < 3; i++) step("R10", 25'($urandom), 1, 1, 0);
        for (int i = 0; i < 5; i++) step("R10", 25'($urandom), i == 2, 0, 0);

        // R1: reset while error held
        step("R1", 25'h3, 1, 0, 0);
        step("R1", 25'h3, 1, 1, 1);
        step("R1", 25'h0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule